// File: doc/BRIEF.md
# Serial Interface Interrupt Logic

This block is the register and interrupt core of an asynchronous serial port. It keeps a write-only control byte and a readable status byte, and from them it produces one active-low interrupt request shared with other interrupting devices. It also drives the request-to-send level and a break indication for the line. The shift registers, the bit-rate timing and the character framing sit outside it. Two strobes stand in for them: one says a received byte has arrived, and one says the transmitter has taken its character.

Software writes the control byte to choose its interrupt sources. One bit enables the receive interrupt. A two-bit transmit field sets the request-to-send level and the transmit interrupt, and it can also force a break. The control byte cannot be read back, so software must keep its own copy. A service routine reads the status byte and tests the receive flag first, then the transmit flag. A read of the receive data clears the receive flag. A write of the transmit data clears the transmit flag.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x02 (receive flag 0, transmit flag 1), irq_n is 1, rts_n is 0 and brk_o is 0.
- R2: rx_arrive sets the receive flag (status bit 0) at the next clock edge. rx_take clears it. When both strobes come in the same cycle, the flag ends up set.
- R3: tx_taken sets the transmit flag (status bit 1) at the next clock edge. tx_load clears it. When both strobes come in the same cycle, the flag ends up clear.
- R4: Control bit 7 enables the receive interrupt. irq_n is 0 while that bit is 1 and the receive flag is 1. With the bit at 0, the receive flag never pulls irq_n low.
- R5: The transmit field is control bits 6:5. The transmit flag pulls irq_n low only while this field is 01. The values 00, 10 and 11 never let the transmit flag raise an interrupt.
- R6: The transmit field also sets the line outputs. For 00 and 01, rts_n is 0 and brk_o is 0. For 10, rts_n is 1 and brk_o is 0. For 11, rts_n is 0 and brk_o is 1.
- R7: Status bit 7 reads 1 exactly when irq_n is 0. Status bits 6:2 always read 0.
- R8: A control write takes effect on the clock edge that follows the write strobe. Control bits 4:0 have no effect. Clearing bits 6:5 leaves the receive interrupt as bit 7 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| rx_arrive | input | 1 | A received byte is ready |
| rx_take | input | 1 | Receive data register is read |
| tx_taken | input | 1 | Transmitter has taken its character |
| tx_load | input | 1 | Transmit data register is written |
| stat_rdata | output | 8 | Status byte: bit 0 receive, bit 1 transmit, bit 7 interrupt |
| irq_n | output | 1 | Shared interrupt request, active low |
| rts_n | output | 1 | Request-to-send level, active low |
| brk_o | output | 1 | Break level requested on the line |

## Verification
The bench builds the block with its default parameters: an 8-bit control byte, the receive flag at status bit 0, the transmit flag at bit 1 and the request mirror at bit 7. These settings bring all four transmit-field codes within reach, as well as each pairing of interrupt enable and flag. They also cover a strobe collision on each flag, where a set and a clear arrive together. A reset in the middle of the run confirms that the state returns to its reset values even after the interrupt and break have been active.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    // Transmit control field codes; the encoding is decoded by the line driver
    typedef enum logic [1:0] {
        TXC_LOW_QUIET = 2'b00,
        TXC_LOW_IRQ   = 2'b01,
        TXC_HIGH      = 2'b10,
        TXC_BREAK     = 2'b11
    } txc_e;

    typedef struct packed {
        logic rx_ie;
        txc_e txc;
    } ctl_t;

    typedef struct packed {
        logic rx_rdy;
        logic tx_emp;
    } flags_t;

endpackage

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg
    import sio_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RXIE_BIT = 7,
    parameter int TXC_LSB  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rx_ie,
    output logic              tx_ie,
    output logic              rts_n,
    output logic              brk
);

    ctl_t ctl_d, ctl_q;

    // Bits outside the decoded fields are accepted and dropped
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d.rx_ie = wdata[RXIE_BIT];
            ctl_d.txc   = txc_e'(wdata[TXC_LSB +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{rx_ie: 1'b0, txc: TXC_LOW_QUIET};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rx_ie = ctl_q.rx_ie;
        tx_ie = 1'b0;
        rts_n = 1'b0;
        brk   = 1'b0;
        unique case (ctl_q.txc)
            TXC_LOW_QUIET: ;
            TXC_LOW_IRQ:   tx_ie = 1'b1;
            TXC_HIGH:      rts_n = 1'b1;
            TXC_BREAK:     brk   = 1'b1;
            default:       ;
        endcase
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctl_q)) else $error("control changed without write"); // R8

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_ie, rts_n, brk})) else $error("transmit field decode overlap"); // R6

endmodule

// File: rtl/sio_stat_flags.sv
module sio_stat_flags
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_arrive,
    input  logic rx_take,
    input  logic tx_taken,
    input  logic tx_load,
    output logic rx_rdy,
    output logic tx_emp
);

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        // Receive: a new byte outranks a read in the same cycle
        if (rx_take)   flg_d.rx_rdy = 1'b0;
        if (rx_arrive) flg_d.rx_rdy = 1'b1;
        // Transmit: a new load outranks the hand-off in the same cycle
        if (tx_taken)  flg_d.tx_emp = 1'b1;
        if (tx_load)   flg_d.tx_emp = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '{rx_rdy: 1'b0, tx_emp: 1'b1};
        end else begin
            flg_q <= flg_d;
        end
    end

    assign rx_rdy = flg_q.rx_rdy;
    assign tx_emp = flg_q.tx_emp;

    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arrive |=> rx_rdy) else $error("receive flag not set"); // R2

    AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && !rx_arrive) |=> !rx_rdy) else $error("receive flag not cleared"); // R2

    AST_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_emp) else $error("transmit flag not cleared"); // R3

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
    import sio_irq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RX_RDY_BIT = 0,
    parameter int TX_EMP_BIT = 1,
    parameter int IRQ_BIT    = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              rx_arrive,
    input  logic              rx_take,
    input  logic              tx_taken,
    input  logic              tx_load,
    output logic [DATA_W-1:0] stat_rdata,
    output logic              irq_n,
    output logic              rts_n,
    output logic              brk_o
);

    localparam int RXIE_BIT = DATA_W - 1;
    localparam int TXC_LSB  = DATA_W - 3;

    logic rx_ie, tx_ie, rx_rdy, tx_emp, req;

    sio_ctl_reg #(
        .DATA_W  (DATA_W),
        .RXIE_BIT(RXIE_BIT),
        .TXC_LSB (TXC_LSB)
    ) u_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (ctl_wr),
        .wdata(ctl_wdata),
        .rx_ie(rx_ie),
        .tx_ie(tx_ie),
        .rts_n(rts_n),
        .brk  (brk_o)
    );

    sio_stat_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_arrive(rx_arrive),
        .rx_take  (rx_take),
        .tx_taken (tx_taken),
        .tx_load  (tx_load),
        .rx_rdy   (rx_rdy),
        .tx_emp   (tx_emp)
    );

    always_comb begin
        req   = (rx_ie && rx_rdy) || (tx_ie && tx_emp);
        irq_n = !req;
        stat_rdata             = '0;
        stat_rdata[RX_RDY_BIT] = rx_rdy;
        stat_rdata[TX_EMP_BIT] = tx_emp;
        stat_rdata[IRQ_BIT]    = req;
    end

    AST_QUIET_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[DATA_W-1 -: 3] == 3'b000) |=> irq_n)
        else $error("interrupt with all sources off"); // R4

    AST_BRK_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> !rts_n) else $error("break with rts high"); // R6

    AST_STAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[IRQ_BIT] != irq_n) else $error("status mirror mismatch"); // R7

endmodule

// File: tb/sio_irq_ctrl_tb.sv
module sio_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rx_arrive = 1'b0, rx_take = 1'b0, tx_taken = 1'b0, tx_load = 1'b0;
    logic [7:0] stat_rdata;
    logic       irq_n, rts_n, brk_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rx_arrive(rx_arrive), .rx_take(rx_take), .tx_taken(tx_taken), .tx_load(tx_load),
        .stat_rdata(stat_rdata), .irq_n(irq_n), .rts_n(rts_n), .brk_o(brk_o)
    );

    // {wr, wdata[7:0], rx_arrive, rx_take, tx_taken, tx_load, exp_stat[7:0], exp_irq_n, exp_rts_n, exp_brk}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 8'h80, 4'b0000, 8'h02, 3'b100},
        {1'b0, 8'h00, 4'b1000, 8'h83, 3'b000},
        {1'b0, 8'h00, 4'b0100, 8'h02, 3'b100},
        {1'b1, 8'h20, 4'b0000, 8'h82, 3'b000},
        {1'b0, 8'h00, 4'b0001, 8'h00, 3'b100},
        {1'b0, 8'h00, 4'b0010, 8'h82, 3'b000},
        {1'b1, 8'h00, 4'b0000, 8'h02, 3'b100},
        {1'b1, 8'h40, 4'b0000, 8'h02, 3'b110},
        {1'b1, 8'h60, 4'b0000, 8'h02, 3'b101},
        {1'b1, 8'hA0, 4'b0000, 8'h82, 3'b000},
        {1'b0, 8'h00, 4'b1100, 8'h83, 3'b000},
        {1'b1, 8'h80, 4'b0000, 8'h83, 3'b000},
        {1'b0, 8'h00, 4'b0011, 8'h81, 3'b000},
        {1'b0, 8'h00, 4'b0100, 8'h00, 3'b100},
        {1'b1, 8'h1F, 4'b0000, 8'h00, 3'b100},
        {1'b0, 8'h00, 4'b1000, 8'h01, 3'b100}
    };

    localparam string TAGS [NVEC] = '{
        "R4", "R4", "R2", "R5", "R3", "R3", "R5", "R6",
        "R6", "R8", "R2", "R8", "R3", "R7", "R8", "R4"
    };

    task automatic check(input string tag, input logic [7:0] exp_stat,
                         input logic exp_irq, input logic exp_rts, input logic exp_brk);
        checks++;
        if (stat_rdata !== exp_stat || irq_n !== exp_irq || rts_n !== exp_rts || brk_o !== exp_brk) begin
            errors++;
            $display("FAIL %s: stat=%02h irq_n=%b rts_n=%b brk=%b expected stat=%02h irq_n=%b rts_n=%b brk=%b",
                     tag, stat_rdata, irq_n, rts_n, brk_o, exp_stat, exp_irq, exp_rts, exp_brk);
        end
    endtask

    task automatic idle();
        ctl_wr = 1'b0; ctl_wdata = '0;
        rx_arrive = 1'b0; rx_take = 1'b0; tx_taken = 1'b0; tx_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h02, 1'b1, 1'b0, 1'b0);   // R1 while in reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h02, 1'b1, 1'b0, 1'b0);   // R1 after release

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ctl_wr    = VEC[i][23];
            ctl_wdata = VEC[i][22:15];
            {rx_arrive, rx_take, tx_taken, tx_load} = VEC[i][14:11];
            @(negedge clk);
            check(TAGS[i], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
            idle();
        end

        // R8: write strobe has no effect before the clock edge
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'h80;
        #1;
        check("R8", 8'h01, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R8", 8'h81, 1'b0, 1'b0, 1'b0);
        idle();

        // R6: break state then mid-run reset returns everything (R1)
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'hE0;
        @(negedge clk);
        idle();
        check("R6", 8'h81, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h02, 1'b1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule